// File: doc/BRIEF.md
# Opcode-driven SPI transfer engine

This block is a single SPI master that runs one transfer described by a two-byte header held in a shared byte buffer. The host first loads the buffer through a simple byte port: header at offsets 0 and 1, little-endian, then any transmit payload from offset 2. It then writes a command word that names a slave line and either starts the transfer at once or arms it to start on an external trigger. The engine reads the header and checks it against the buffer space. It asserts the chosen chip select, then moves the bytes MSB first on one data lane or on two. Each received byte goes back into the same buffer from offset 0, so the host reads the results where it wrote the header.

Header layout: bits [15:13] give the operation (0 sleep, 1 read-write, 2 write-only, 3 read-only, 4 set-interrupt). Bit 11 requests two data lanes. Bits [9:0] give the byte count. A read-only transfer may use all 512 bytes. Any operation that transmits is limited to 510 bytes, because the payload starts after the header. The serial clock idles low. Data leaves on its falling edge and is sampled on its rising edge. In single-lane mode `sdo_o[0]` is the output lane and `sdi_i[1]` is the input lane.

Register port addresses: 0 command, 1 status (write 1 to clear), 2 interrupt mask, 3 chip-select idle levels. Command word: bits [3:0] give the command (0 no-op, 1 start, 2 arm for trigger, 3 halt, 4 flush) and bits [14:12] give the slave line. Status bits: bit 0 done, bit 4 invalid control. Bits 1, 2 and 3 are reserved for overflow, underflow and poll-timeout events, which this engine never raises.

Top module: `spi_opcmd_engine`

## Requirements
- R1: After reset the status is 0, `irq_o`, `busy_o` and `sclk_o` are 0, and every chip select sits at its idle level of 1.
- R2: A write-only header (op 2) with a count of 1 to 510 shifts buffer bytes 2 to count+1 out MSB first on `sdo_o[0]`, one bit per clock, and then sets status bit 0.
- R3: A read-write header (op 1) sends byte 2+i while the byte received on `sdi_i[1]` is stored at offset i, for every i below the count.
- R4: A read-only header (op 3) accepts counts up to 512, holds the output lane low, and stores the received bytes from offset 0.
- R5: With header bit 11 set, a write-only or read-only transfer moves two bits per clock, the higher bit on lane 1.
- R6: A count of 0, a count above the limit for its operation, dual lanes on a read-write, or an op code above 4 sets status bit 4 with no clock edge and no done bit.
- R7: Register 3 holds one idle level per line. During a transfer only the selected line leaves its idle level, and it returns to idle afterwards.
- R8: A start command that arrives while a transfer is running is ignored. Its line never becomes active and no second transfer follows.
- R9: Command 2 waits without clocking until `ext_trig` is high. A flush or a halt while the engine waits cancels the armed start.
- R10: A halt during a transfer stops at the next byte boundary, releases chip select and leaves status bit 0 clear.
- R11: Status bits are sticky until 1 is written to them at address 1, and `irq_o` is high exactly when a set status bit is enabled in the mask.
- R12: Sleep (op 0) and set-interrupt (op 4) headers set status bit 0 without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Buffer byte write enable |
| buf_addr | input | 9 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle after the address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| ext_trig | input | 1 | External start trigger for an armed command |
| status_o | output | 8 | Sticky status bits |
| irq_o | output | 1 | Masked interrupt request |
| busy_o | output | 1 | A command is armed or running |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 2 | Serial data out, lane 1 and lane 0 |
| sdi_i | input | 2 | Serial data in, lane 1 and lane 0 |
| cs_o | output | 8 | Chip-select levels, one per line |

## Verification
The assertions assume that the host leaves the buffer alone while `busy_o` is high, and that the header in place at the start describes the whole transfer. The bench therefore loads the header, payload and slave data only while the engine is idle. The only commands it issues during a transfer are the halt and the conflicting start that it tests on purpose. It also assumes that a transfer's header stays within its own space. Random counts stay inside the legal range, and the over-limit counts appear only in the directed invalid cases.

// File: rtl/spi_opcmd_pkg.sv
`timescale 1ns/1ps
package spi_opcmd_pkg;
  localparam int HDR_BYTES = 2;

  localparam logic [2:0] OP_SLEEP  = 3'd0;
  localparam logic [2:0] OP_XFER   = 3'd1;
  localparam logic [2:0] OP_TXONLY = 3'd2;
  localparam logic [2:0] OP_RXONLY = 3'd3;
  localparam logic [2:0] OP_FLAG   = 3'd4;

  localparam logic [3:0] CMD_NOP  = 4'd0;
  localparam logic [3:0] CMD_GO   = 4'd1;
  localparam logic [3:0] CMD_ARM  = 4'd2;
  localparam logic [3:0] CMD_STOP = 4'd3;
  localparam logic [3:0] CMD_DROP = 4'd4;

  localparam int ST_DONE   = 0;
  localparam int ST_BADCTL = 4;

  localparam logic [1:0] RA_CMD   = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_MASK  = 2'd2;
  localparam logic [1:0] RA_CSPOL = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_ARMED, S_HDR_A, S_HDR_B, S_DEC, S_FETCH, S_LOAD, S_SHIFT, S_FIN
  } eng_state_e;
endpackage

// File: rtl/spi_opbuf_ram.sv
`timescale 1ns/1ps
module spi_opbuf_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  // Two synchronous ports; on a same-address double write port b wins.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spi_opx_shifter.sv
`timescale 1ns/1ps
module spi_opx_shifter #(
  parameter int HALF_DIV = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       dual,
  input  logic [7:0] tx_byte,
  input  logic [1:0] sdi,
  output logic       sclk,
  output logic [1:0] sdo,
  output logic [7:0] rx_byte,
  output logic       done
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          run_q, dual_q;
  logic [DW-1:0] div_q;
  logic [2:0]    left_q;
  logic [7:0]    tx_q, nx;

  assign nx = dual_q ? {tx_q[5:0], 2'b00} : {tx_q[6:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; dual_q <= 1'b0; div_q <= '0; left_q <= '0;
      tx_q <= '0; rx_byte <= '0; sclk <= 1'b0; sdo <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tx_q   <= tx_byte;
        dual_q <= dual;
        sdo    <= dual ? tx_byte[7:6] : {1'b0, tx_byte[7]};
        left_q <= dual ? 3'd3 : 3'd7;
        div_q  <= '0;
        sclk   <= 1'b0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (div_q == DW'(HALF_DIV - 1)) begin
          div_q <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= dual_q ? {rx_byte[5:0], sdi} : {rx_byte[6:0], sdi[1]};
          end else begin
            sclk <= 1'b0;
            if (left_q == 3'd0) begin
              run_q <= 1'b0;
              done  <= 1'b1;
              sdo   <= '0;
            end else begin
              left_q <= left_q - 3'd1;
              tx_q   <= nx;
              sdo    <= dual_q ? nx[7:6] : {1'b0, nx[7]};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  // R2: a byte ends only on the falling edge of a high clock phase
  a_r2_done_after_high: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && $past(sclk)));
endmodule

// File: rtl/spi_opcmd_engine.sv
`timescale 1ns/1ps
module spi_opcmd_engine
  import spi_opcmd_pkg::*;
#(
  parameter int              BUF_BYTES  = 512,
  parameter int              NUM_CS     = 8,
  parameter int              HALF_DIV   = 2,
  parameter logic [NUM_CS-1:0] CS_POL_RST = '1
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  input  logic [7:0]                   buf_wdata,
  output logic [7:0]                   buf_rdata,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_addr,
  input  logic [15:0]                  reg_wdata,
  input  logic                         ext_trig,
  output logic [7:0]                   status_o,
  output logic                         irq_o,
  output logic                         busy_o,
  output logic                         sclk_o,
  output logic [1:0]                   sdo_o,
  input  logic [1:0]                   sdi_i,
  output logic [NUM_CS-1:0]            cs_o
);
  localparam int AW   = $clog2(BUF_BYTES);
  localparam int CW   = AW + 1;
  localparam int SELW = $clog2(NUM_CS);
  localparam logic [CW-1:0] MAX_RX = CW'(BUF_BYTES);
  localparam logic [CW-1:0] MAX_TX = CW'(BUF_BYTES - HDR_BYTES);

  eng_state_e        state_q;
  logic [7:0]        lo_q, st_q, mask_q, st_set, st_clr;
  logic [CW-1:0]     cnt_q, idx_q;
  logic [SELW-1:0]   sel_q;
  logic [NUM_CS-1:0] pol_q, cs_q, act_vec;
  logic              tx_q, rx_q, dual_q, act_q, halt_q;

  logic          b_we, sh_start, sh_done;
  logic [AW-1:0] b_addr;
  logic [7:0]    b_rdata, sh_rx;

  spi_opbuf_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
    .clk(clk),
    .a_we(buf_we), .a_addr(buf_addr), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(sh_rx), .b_rdata(b_rdata)
  );

  spi_opx_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .dual(dual_q),
    .tx_byte(tx_q ? b_rdata : 8'h00), .sdi(sdi_i),
    .sclk(sclk_o), .sdo(sdo_o), .rx_byte(sh_rx), .done(sh_done)
  );

  // Header decode, valid while the high byte is on the read port (S_DEC)
  logic [15:0]   hdr;
  logic [2:0]    h_op;
  logic [CW-1:0] h_cnt, h_lim;
  logic          h_xfer, h_bad, unused_hdr;
  assign hdr        = {b_rdata, lo_q};
  assign h_op       = hdr[15:13];
  assign h_cnt      = hdr[CW-1:0];
  assign h_xfer     = (h_op == OP_XFER) || (h_op == OP_TXONLY) || (h_op == OP_RXONLY);
  assign h_lim      = (h_op == OP_RXONLY) ? MAX_RX : MAX_TX;
  assign h_bad      = (h_op > OP_FLAG) ||
                      (h_xfer && ((h_cnt == '0) || (h_cnt > h_lim) ||
                                  (hdr[11] && h_op == OP_XFER)));
  assign unused_hdr = ^{hdr[12], hdr[10]};

  logic       cmd_wr, unused_cmd;
  logic [3:0] cmd;
  assign cmd_wr     = reg_we && (reg_addr == RA_CMD);
  assign cmd        = reg_wdata[3:0];
  assign unused_cmd = ^{reg_wdata[15], reg_wdata[11:4]};

  always_comb begin
    b_addr   = '0;
    b_we     = 1'b0;
    sh_start = 1'b0;
    case (state_q)
      S_HDR_B: b_addr = AW'(1);
      S_FETCH: b_addr = AW'(idx_q + CW'(HDR_BYTES));
      S_LOAD:  sh_start = 1'b1;
      S_SHIFT: begin
        b_addr = idx_q[AW-1:0];
        b_we   = sh_done && rx_q;
      end
      default: b_addr = '0;
    endcase
  end

  always_comb begin
    st_set = '0;
    st_set[ST_BADCTL] = (state_q == S_DEC) && h_bad && !halt_q;
    st_set[ST_DONE]   = ((state_q == S_DEC) && !h_bad && !h_xfer && !halt_q) ||
                        ((state_q == S_FIN) && !halt_q);
    st_clr = (reg_we && reg_addr == RA_STAT) ? reg_wdata[7:0] : 8'h00;
  end

  assign act_vec  = act_q ? (NUM_CS'(1) << sel_q) : '0;
  assign status_o = st_q;
  assign irq_o    = |(st_q & mask_q);
  assign busy_o   = (state_q != S_IDLE);
  assign cs_o     = cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; lo_q <= '0; st_q <= '0; mask_q <= '0;
      cnt_q <= '0; idx_q <= '0; sel_q <= '0; pol_q <= CS_POL_RST; cs_q <= CS_POL_RST;
      tx_q <= 1'b0; rx_q <= 1'b0; dual_q <= 1'b0; act_q <= 1'b0; halt_q <= 1'b0;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      cs_q <= pol_q ^ act_vec;
      if (reg_we && reg_addr == RA_MASK)  mask_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == RA_CSPOL) pol_q  <= reg_wdata[NUM_CS-1:0];
      case (state_q)
        S_IDLE: if (cmd_wr && (cmd == CMD_GO || cmd == CMD_ARM)) begin
          sel_q   <= reg_wdata[12 +: SELW];
          halt_q  <= 1'b0;
          state_q <= (cmd == CMD_GO) ? S_HDR_A : S_ARMED;
        end
        S_ARMED: begin
          if (cmd_wr && (cmd == CMD_STOP || cmd == CMD_DROP)) state_q <= S_IDLE;
          else if (ext_trig)                                   state_q <= S_HDR_A;
        end
        S_HDR_A: state_q <= S_HDR_B;
        S_HDR_B: begin
          lo_q    <= b_rdata;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (halt_q || h_bad || !h_xfer) begin
            state_q <= S_IDLE;
          end else begin
            cnt_q   <= h_cnt;
            tx_q    <= (h_op != OP_RXONLY);
            rx_q    <= (h_op != OP_TXONLY);
            dual_q  <= hdr[11];
            idx_q   <= '0;
            act_q   <= 1'b1;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: state_q <= S_LOAD;
        S_LOAD:  state_q <= S_SHIFT;
        S_SHIFT: if (sh_done) begin
          if (halt_q || idx_q == cnt_q - CW'(1)) state_q <= S_FIN;
          else begin
            idx_q   <= idx_q + CW'(1);
            state_q <= S_FETCH;
          end
        end
        S_FIN: begin
          act_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
      if (cmd_wr && cmd == CMD_STOP && state_q != S_IDLE && state_q != S_ARMED)
        halt_q <= 1'b1;
    end
  end

  // R6: no serial clock while the engine is idle
  a_r6_idle_no_clock: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !sclk_o);

  // R8: a start while bytes are moving does not restart the sequence
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT && cmd_wr && cmd == CMD_GO) |=> (state_q != S_HDR_A));

  // R11: status bits only fall through a write-one-to-clear
  a_r11_sticky_status: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == RA_STAT) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R7: settled idle engine shows only the idle levels
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && $past(state_q) == S_IDLE && $past(pol_q) == pol_q)
      |-> (cs_o == pol_q));

  // R5: two lanes never run on a read-write transfer
  a_r5_no_dual_rw: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT) |-> !(dual_q && tx_q && rx_q));
endmodule

// File: tb/spi_opcmd_engine_bench.sv
`timescale 1ns/1ps
module spi_opcmd_engine_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        buf_we = 0, reg_we = 0, ext_trig = 0;
  logic [8:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0, buf_rdata, status_o, cs_o;
  logic [1:0]  reg_addr = '0, sdo_o, sdi_i;
  logic [15:0] reg_wdata = '0;
  logic        irq_o, busy_o, sclk_o;

  always #2.5 clk = ~clk;

  spi_opcmd_engine u_spi_opcmd_engine (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ext_trig(ext_trig), .status_o(status_o), .irq_o(irq_o), .busy_o(busy_o),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .cs_o(cs_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] bmem [512];
  logic [7:0] sdat [512];
  logic [7:0] mcap [512];
  logic [7:0] exp_tx [512];
  logic [7:0] macc;
  int   mcnt, mbit, rises, sidx, sst, sel_now;
  logic dual_now = 0, mon_on = 0, cs_seen, cs_bad;
  logic [7:0] pol_now = 8'hFF;

  // Slave model: presents data before each rising edge, advances on falling
  always @* begin
    if (dual_now) sdi_i = {sdat[sidx % 512][7 - 2*sst], sdat[sidx % 512][6 - 2*sst]};
    else          sdi_i = {sdat[sidx % 512][7 - sst], 1'b0};
  end
  always @(negedge sclk_o) begin
    sst = sst + 1;
    if (sst == (dual_now ? 4 : 8)) begin sst = 0; sidx = sidx + 1; end
  end
  always @(posedge sclk_o) begin
    rises = rises + 1;
    if (dual_now) begin macc = {macc[5:0], sdo_o}; mbit = mbit + 2; end
    else          begin macc = {macc[6:0], sdo_o[0]}; mbit = mbit + 1; end
    if (mbit == 8) begin
      if (mcnt < 512) mcap[mcnt] = macc;
      mcnt = mcnt + 1; mbit = 0;
    end
  end
  always @(negedge clk) if (mon_on) begin
    for (int i = 0; i < 8; i++)
      if (cs_o[i] != pol_now[i]) begin
        if (i == sel_now) cs_seen = 1'b1; else cs_bad = 1'b1;
      end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_buf(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_addr = 9'(a); buf_wdata = d;
    @(negedge clk); buf_we = 0;
    bmem[a] = d;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] d);
    @(negedge clk); buf_addr = 9'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 2'd3) pol_now = d[7:0];
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy_o && n < 60000) begin @(negedge clk); n++; end
    chk(!busy_o, {tag, " engine returns idle"}, busy_o, 0);
    tick(2);
  endtask

  task automatic begin_xfer(input int op, input bit multi, input int cnt,
                            input int line, input logic [3:0] cmd);
    logic [9:0] c10 = 10'(cnt);
    wr_buf(0, c10[7:0]);
    wr_buf(1, {3'(op), 1'b0, multi, 1'b0, c10[1+8:8]});
    for (int i = 0; i < 512; i++) exp_tx[i] = (i + 2 < 512) ? bmem[i + 2] : 8'h00;
    mcnt = 0; mbit = 0; rises = 0; sidx = 0; sst = 0; macc = 0;
    dual_now = multi; sel_now = line; cs_seen = 0; cs_bad = 0; mon_on = 1;
    wr_reg(2'd0, {1'b0, 3'(line), 8'h00, cmd});
  endtask

  task automatic end_xfer(input int op, input int cnt, input string tag);
    int bad = 0;
    logic [7:0] d;
    mon_on = 0;
    chk(mcnt == cnt, {tag, " byte count"}, mcnt, cnt);
    for (int i = 0; i < cnt && i < 512; i++)
      if (mcap[i] !== ((op == 3) ? 8'h00 : exp_tx[i])) bad++;
    chk(bad == 0, {tag, " serial output bytes"}, bad, 0);
    if (op != 2) begin
      bad = 0;
      for (int i = 0; i < cnt; i++) begin
        rd_buf(i, d);
        if (d !== sdat[i]) bad++;
        bmem[i] = sdat[i];
      end
      chk(bad == 0, {tag, " received bytes stored from offset 0"}, bad, 0);
    end
    chk(status_o == 8'h01, {tag, " done bit set"}, status_o, 1);
    chk(cs_seen && !cs_bad, "R7 only selected line active", cs_bad, 0);
    chk(cs_o == pol_now, "R7 chip select back at idle", cs_o, pol_now);
    wr_reg(2'd1, 16'h00FF);
    chk(status_o == 8'h00, "R11 status cleared by writing 1", status_o, 0);
  endtask

  task automatic run_xfer(input int op, input bit multi, input int cnt,
                          input int line, input string tag);
    if (op != 3) for (int i = 0; i < cnt; i++) wr_buf(2 + i, 8'($urandom));
    for (int i = 0; i < 512; i++) sdat[i] = 8'($urandom);
    begin_xfer(op, multi, cnt, line, 4'd1);
    wait_idle(tag);
    end_xfer(op, cnt, tag);
  endtask

  task automatic bad_hdr(input int op, input bit multi, input int cnt, input string tag);
    begin_xfer(op, multi, cnt, 1, 4'd1);
    wait_idle(tag);
    mon_on = 0;
    chk(status_o == 8'h10, {tag, " invalid bit alone"}, status_o, 16);
    chk(rises == 0 && !cs_seen, {tag, " no clock or select"}, rises, 0);
    wr_reg(2'd1, 16'h00FF);
  endtask

  initial begin
    #(5 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin bmem[i] = 0; sdat[i] = 0; end
    tick(4); rst = 0; tick(2);
    // R1 reset state
    chk(status_o == 0 && !irq_o && !busy_o, "R1 status, irq, busy after reset", status_o, 0);
    chk(cs_o == 8'hFF && !sclk_o, "R1 chip selects idle high, clock low", cs_o, 255);

    wr_reg(2'd3, 16'h00F0); tick(2);
    chk(cs_o == 8'hF0, "R7 idle levels follow polarity register", cs_o, 240);

    // Random mix of legal transfers
    for (int k = 0; k < 8; k++) begin
      int op = 1 + int'($urandom % 3);
      bit mb = (op != 1) ? 1'($urandom) : 1'b0;
      run_xfer(op, mb, 1 + int'($urandom % 40), int'($urandom % 8),
               op == 1 ? "R3 read-write" : (mb ? "R5 dual" : (op == 2 ? "R2 write" : "R4 read")));
    end
    run_xfer(2, 1'b1, 9, 3, "R5 dual write");
    run_xfer(3, 1'b1, 9, 6, "R5 dual read");
    run_xfer(2, 1'b0, 510, 0, "R2 write at 510-byte limit");
    run_xfer(3, 1'b0, 512, 7, "R4 read at 512-byte limit");

    // R6 invalid headers
    bad_hdr(2, 1'b0, 511, "R6 write over limit");
    bad_hdr(3, 1'b0, 513, "R6 read over limit");
    bad_hdr(1, 1'b0, 0,   "R6 zero count");
    bad_hdr(1, 1'b1, 4,   "R6 dual read-write");
    bad_hdr(5, 1'b0, 4,   "R6 undefined op");

    // R12 sleep and set-interrupt
    begin_xfer(0, 1'b0, 5, 2, 4'd1); wait_idle("R12 sleep"); mon_on = 0;
    chk(status_o == 8'h01 && rises == 0, "R12 sleep sets done without clock", rises, 0);
    wr_reg(2'd1, 16'h0001);
    begin_xfer(4, 1'b0, 5, 2, 4'd1); wait_idle("R12 set-interrupt"); mon_on = 0;
    chk(status_o == 8'h01 && rises == 0, "R12 set-interrupt sets done", status_o, 1);

    // R11 mask and write-one-to-clear
    wr_reg(2'd2, 16'h0000);
    chk(!irq_o, "R11 masked done gives no irq", irq_o, 0);
    wr_reg(2'd2, 16'h0001);
    chk(irq_o, "R11 enabled done raises irq", irq_o, 1);
    wr_reg(2'd1, 16'h00FE);
    chk(status_o == 8'h01 && irq_o, "R11 writing 0 keeps bit", status_o, 1);
    wr_reg(2'd1, 16'h0001);
    chk(status_o == 8'h00 && !irq_o, "R11 clear drops irq", irq_o, 0);
    wr_reg(2'd2, 16'h0000);

    // R8 start while busy
    for (int i = 0; i < 20; i++) wr_buf(2 + i, 8'($urandom));
    begin_xfer(2, 1'b0, 20, 2, 4'd1);
    tick(60);
    wr_reg(2'd0, {1'b0, 3'd5, 8'h00, 4'd1});
    wait_idle("R8");
    tick(30);
    chk(!busy_o && mcnt == 20, "R8 no second transfer after busy start", mcnt, 20);
    end_xfer(2, 20, "R8 original transfer");

    // R10 halt
    for (int i = 0; i < 30; i++) wr_buf(2 + i, 8'($urandom));
    begin_xfer(2, 1'b0, 30, 4, 4'd1);
    while (mcnt < 3) @(negedge clk);
    wr_reg(2'd0, 16'h0003);
    wait_idle("R10");
    mon_on = 0;
    chk(mcnt >= 3 && mcnt < 30 && mbit == 0, "R10 stopped on a byte boundary", mcnt, 3);
    chk(status_o == 8'h00, "R10 halt leaves done clear", status_o, 0);
    chk(cs_o == pol_now, "R10 chip select released", cs_o, pol_now);

    // R9 trigger, then flush of an armed start
    for (int i = 0; i < 4; i++) wr_buf(2 + i, 8'($urandom));
    begin_xfer(2, 1'b0, 4, 1, 4'd2);
    tick(30);
    chk(busy_o && rises == 0, "R9 armed start waits for trigger", rises, 0);
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    wait_idle("R9");
    end_xfer(2, 4, "R9 triggered transfer");
    begin_xfer(2, 1'b0, 4, 1, 4'd2);
    tick(5);
    wr_reg(2'd0, 16'h0004);
    tick(2);
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    tick(20); mon_on = 0;
    chk(!busy_o && rises == 0 && status_o == 0, "R9 flush cancels armed start", rises, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule